// File: doc/BRIEF.md
# Latched-Address Nibble Register Bus Interface

This block is the CPU-facing side of a small peripheral with sixteen 4-bit registers. It accepts a 4-bit address, an active-high enable select, an active-low chip select, active-low read and write strobes, and an address-latch-enable input. The 4-bit bidirectional data bus is split into a data-in input, a data-out output and an output-enable output. The block decides when the bus is driven, writes incoming data into the addressed register, and flags the illegal case of both strobes asserted together.

The same block works on a demultiplexed bus, with the latch enable tied high, and on a multiplexed bus. While the latch enable is high, the address and the active-low chip select pass straight through. When it falls, both values are frozen and stay frozen until it rises again.

The active-high enable select doubles as a standby indicator. Whenever it is low the bus is released, and two control bits (bits 0 and 1 of register 13) are forced to zero.

The design runs on one system clock. The read, write and latch-enable strobes each pass through a two-flop synchronizer.

Top module: `nibble_bus_if`

## Requirements
- R1: The bus is driven (`dat_oe_o`=1) only when `chip_en_i` is high and the effective chip select (live or latched) is low. With `chip_en_i` high and the effective chip select high, the bus stays undriven.
- R2: When the block is selected with `rd_n_i` low and `wr_n_i` high, `dat_oe_o` is 1 and `dat_o` shows the addressed register. This holds from at most three clock edges after the strobes settle, and for as long as `rd_n_i` stays low.
- R3: When the block is selected with `rd_n_i` high, a falling edge on `wr_n_i` stores `dat_i` into the addressed register. The bus is not driven in this input mode.
- R4: With `rd_n_i` and `wr_n_i` both low while selected, `conflict_o` is 1, the bus is not driven, and no register is written.
- R5: When `chip_en_i` is low, the bus is undriven whatever the other inputs are.
- R6: While `ale_i` is high, the address and the chip select pass through. While `ale_i` is low, the values they held when it fell are used, and later changes on `addr_i` or `chip_sel_n_i` have no effect.
- R7: With `ale_i` held high, reads and writes use the live address and chip select.
- R8: While `chip_en_i` is low, bits 0 and 1 of register 13 are cleared to 0. Bits 2 and 3 of register 13, and all other registers, keep their values.
- R9: After `rst_n` is asserted low at a clock edge, all registers are 0, `dat_oe_o` is 0 and `conflict_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 4 | Register address |
| chip_en_i | input | 1 | Active-high enable select; low means standby |
| chip_sel_n_i | input | 1 | Active-low chip select, latched together with the address |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe; the write happens on its falling edge |
| ale_i | input | 1 | Address latch enable: transparent when high, holding when low |
| dat_i | input | 4 | Data bus, inbound half |
| dat_o | output | 4 | Data bus, outbound half (0 when not driven) |
| dat_oe_o | output | 1 | Data bus output enable |
| conflict_o | output | 1 | Both strobes low while selected |

## Verification
A wrong register state only shows at the ports through a later read of that address. It then appears on `dat_o` within three edges of the read strobe falling, so every write and every standby clear is followed by a read-back. Faults in the select decode or the latch path show at once as a wrong `dat_oe_o` or `conflict_o` level once the synchronizers settle. Latch faults show as the wrong register being read after the address lines have moved.

// File: rtl/nibble_bus_if.sv
module nibble_bus_if #(
  parameter int AW        = 4,
  parameter int DW        = 4,
  parameter int CTRL_ADDR = 13,
  parameter int HOLD_BIT  = 0,
  parameter int RST_BIT   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          chip_en_i,
  input  logic          chip_sel_n_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic          ale_i,
  input  logic [DW-1:0] dat_i,
  output logic [DW-1:0] dat_o,
  output logic          dat_oe_o,
  output logic          conflict_o
);
  localparam int DEPTH = 1 << AW;

  logic [1:0]    rd_sy, wr_sy, ale_sy;
  logic          wr_d;
  logic [AW-1:0] addr_hold;
  logic          csn_hold;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_sy  <= 2'b11;
      wr_sy  <= 2'b11;
      ale_sy <= 2'b11;
      wr_d   <= 1'b1;
    end else begin
      rd_sy  <= {rd_sy[0], rd_n_i};
      wr_sy  <= {wr_sy[0], wr_n_i};
      ale_sy <= {ale_sy[0], ale_i};
      wr_d   <= wr_sy[1];
    end
  end

  wire rd_s  = rd_sy[1];
  wire wr_s  = wr_sy[1];
  wire ale_s = ale_sy[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_hold <= '0;
      csn_hold  <= 1'b1;
    end else if (ale_s) begin
      addr_hold <= addr_i;
      csn_hold  <= chip_sel_n_i;
    end
  end

  wire [AW-1:0] addr_eff = ale_s ? addr_i : addr_hold;
  wire          csn_eff  = ale_s ? chip_sel_n_i : csn_hold;
  wire          sel      = chip_en_i & ~csn_eff;
  wire          wr_fall  = wr_d & ~wr_s;
  wire          do_write = sel & rd_s & wr_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_write) mem[addr_eff] <= dat_i;
      if (!chip_en_i) begin
        mem[CTRL_ADDR][HOLD_BIT] <= 1'b0;
        mem[CTRL_ADDR][RST_BIT]  <= 1'b0;
      end
    end
  end

  assign dat_oe_o   = sel & ~rd_s & wr_s;
  assign conflict_o = sel & ~rd_s & ~wr_s;
  assign dat_o      = dat_oe_o ? mem[addr_eff] : '0;
endmodule

module nibble_bus_if_chk #(
  parameter int AW = 4,
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chip_en_i,
  input logic          dat_oe_o,
  input logic          conflict_o,
  input logic [DW-1:0] dat_o,
  input logic [AW-1:0] addr_eff,
  input logic [1:0]    ctl_bits
);
  assert_standby_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en_i |-> !dat_oe_o);
  assert_conflict_undriven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_o |-> !dat_oe_o);
  assert_standby_clears_ctl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en_i |=> ctl_bits == 2'b00);
  assert_read_data_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_oe_o && $past(dat_oe_o) && $stable(addr_eff)) |-> $stable(dat_o));
endmodule

bind nibble_bus_if nibble_bus_if_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en_i(chip_en_i), .dat_oe_o(dat_oe_o),
  .conflict_o(conflict_o), .dat_o(dat_o), .addr_eff(addr_eff),
  .ctl_bits({mem[CTRL_ADDR][RST_BIT], mem[CTRL_ADDR][HOLD_BIT]})
);

// File: tb/tb_nibble_bus_if.sv
module tb_nibble_bus_if;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] addr_i = 0;
  logic       chip_en_i = 1, chip_sel_n_i = 0, rd_n_i = 1, wr_n_i = 1, ale_i = 1;
  logic [3:0] dat_i = 0;
  logic [3:0] dat_o;
  logic       dat_oe_o, conflict_o;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  nibble_bus_if dut (.*);

  // {chip_en, chip_sel_n, rd_n, wr_n, exp_oe, exp_conflict}
  localparam logic [5:0] VEC [9] = '{
    6'b1001_10, 6'b1010_00, 6'b1000_01, 6'b1011_00, 6'b0001_00,
    6'b0101_00, 6'b0000_00, 6'b1101_00, 6'b1100_00 };

  task automatic settle(int n = 4);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [3:0] d);
    addr_i = a; dat_i = d; wr_n_i = 0; settle();
    wr_n_i = 1; settle();
  endtask

  task automatic rd(logic [3:0] a, output logic [3:0] d, output logic oe);
    addr_i = a; rd_n_i = 0; settle();
    d = dat_o; oe = dat_oe_o;
    rd_n_i = 1; settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] d;
    logic oe;
    settle(3);
    chk("R9 oe", {7'd0, dat_oe_o}, 8'd0);
    chk("R9 conflict", {7'd0, conflict_o}, 8'd0);
    rst_n = 1; settle();
    rd(4'd6, d, oe);
    chk("R9 reg reset", {3'd0, oe, d}, 8'h10);

    addr_i = 4'd5; dat_i = 4'h3;
    foreach (VEC[i]) begin
      {chip_en_i, chip_sel_n_i, rd_n_i, wr_n_i} = VEC[i][5:2];
      settle();
      chk("R1/R2/R3/R4/R5 table oe", {7'd0, dat_oe_o}, {7'd0, VEC[i][1]});
      chk("R4 table conflict", {7'd0, conflict_o}, {7'd0, VEC[i][0]});
      rd_n_i = 1; wr_n_i = 1; settle();
      chip_en_i = 1; chip_sel_n_i = 0; settle();
    end

    // R3 / R7: write then read back on a demultiplexed bus
    wr(4'd3, 4'hA);
    wr(4'd4, 4'h6);
    rd(4'd3, d, oe);
    chk("R3 R7 readback reg3", {3'd0, oe, d}, 8'h1A);
    rd(4'd4, d, oe);
    chk("R3 R7 readback reg4", {3'd0, oe, d}, 8'h16);

    // R4: both strobes low must not write
    addr_i = 4'd3; dat_i = 4'h5; rd_n_i = 0; settle();
    wr_n_i = 0; settle();
    chk("R4 conflict flag", {6'd0, conflict_o, dat_oe_o}, 8'h02);
    rd_n_i = 1; settle(); wr_n_i = 1; settle();
    rd(4'd3, d, oe);
    chk("R4 no write", {3'd0, oe, d}, 8'h1A);

    // R6: multiplexed cycle, address and select held while ALE low
    wr(4'd7, 4'h9);
    addr_i = 4'd7; chip_sel_n_i = 0; ale_i = 1; settle();
    ale_i = 0; settle();
    addr_i = 4'd2; chip_sel_n_i = 1; settle();
    rd_n_i = 0; settle();
    chk("R6 latched read", {3'd0, dat_oe_o, dat_o}, 8'h19);
    rd_n_i = 1; settle();
    dat_i = 4'hC; wr_n_i = 0; settle(); wr_n_i = 1; settle();
    ale_i = 1; chip_sel_n_i = 0; settle();
    rd(4'd7, d, oe);
    chk("R6 latched write target", {3'd0, oe, d}, 8'h1C);
    rd(4'd2, d, oe);
    chk("R6 live addr untouched", {3'd0, oe, d}, 8'h10);

    // R1: live chip select high with ALE transparent
    chip_sel_n_i = 1; addr_i = 4'd7; rd_n_i = 0; settle();
    chk("R1 deselected", {7'd0, dat_oe_o}, 8'd0);
    rd_n_i = 1; chip_sel_n_i = 0; settle();

    // R8: standby clears control bits 0 and 1 of register 13 only
    wr(4'd13, 4'hF);
    rd(4'd13, d, oe);
    chk("R8 ctl before standby", {3'd0, oe, d}, 8'h1F);
    chip_en_i = 0; settle();
    chk("R5 standby undriven", {7'd0, dat_oe_o}, 8'd0);
    chip_en_i = 1; settle();
    rd(4'd13, d, oe);
    chk("R8 ctl cleared", {3'd0, oe, d}, 8'h1C);
    rd(4'd4, d, oe);
    chk("R8 other reg kept", {3'd0, oe, d}, 8'h16);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule